// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control Write Logic

This block gathers the interrupt conditions of a single UART channel, masks each one with its own enable bit, and picks the most urgent one by a fixed seven-level priority. The winner appears as a six-bit code in the low bits of a status byte that a service routine can read and use directly as a jump index. The same byte reports in its top two bits whether the FIFOs are switched on. An interrupt line follows the pending state.

Two of the seven sources belong to the enhanced flow-control features: a sticky indication that an Xoff or special character was matched, and a flag for a change on the CTS/RTS handshake lines. Both report only while the enhanced-features enable is high. The sticky indication is held inside this block and is released when an Xon character is detected.

The block also holds the write side of the FIFO control register. Bit 0 of a control write switches both FIFOs on or off. Bit 1, written together with bit 0 set, produces a one-cycle pulse that resets the receive FIFO pointers and level counter. The FIFO storage, the shift registers and the baud generator are outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source pending, isr[5:0] is 000001. Bit 0 is 1 exactly when nothing is pending.
- R2: The pending source with the highest priority sets isr[5:0]. From highest to lowest the codes are: line status 000110, receive timeout 001100, receive data ready 000100, transmit ready 000010, modem status 000000, Xoff/special character 010000, CTS/RTS change 100000.
- R3: The status byte is combinational from the condition inputs. When a higher source drops, the next lower pending source is shown in the same cycle.
- R4: ev_flag[i] is reported only while ev_en[i] is 1. The bit index is 0 for line status, 1 for receive timeout, 2 for receive data ready, 3 for transmit ready and 4 for modem status.
- R5: While enh_en is 0, the Xoff and CTS/RTS sources never report, and isr[5:4] stays 00. The CTS/RTS source also needs flow_en, and the Xoff source also needs xoff_en.
- R6: A one-cycle xoff_hit while enh_en is 1 sets the sticky Xoff indication on the next clock edge. The indication stays set until xon_hit is seen. If both arrive in the same cycle, the indication ends clear. An xoff_hit while enh_en is 0 has no effect.
- R7: isr[7:6] is 11 while the FIFOs are enabled and 00 while they are disabled. The FIFOs are disabled after reset.
- R8: A control write (ctl_wr) loads the FIFO-enable state from ctl_wdata[0] on the next clock edge.
- R9: rx_fifo_rst pulses for exactly one cycle after the clock edge that takes a control write with ctl_wdata[1:0] = 11. A write with ctl_wdata[0] = 0 produces no pulse.
- R10: irq is high exactly when isr[0] is 0, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_flag | input | 5 | Latched basic condition flags (line, timeout, rx ready, tx ready, modem) |
| ev_en | input | 5 | Per-source enables for ev_flag |
| flow_chg | input | 1 | CTS/RTS change-of-state flag |
| flow_en | input | 1 | Enable for the CTS/RTS source |
| xoff_hit | input | 1 | Xoff or special character matched (one-cycle event) |
| xon_hit | input | 1 | Xon character received (one-cycle event) |
| xoff_en | input | 1 | Enable for the Xoff source |
| enh_en | input | 1 | Enhanced-features enable |
| ctl_wr | input | 1 | FIFO control register write strobe |
| ctl_wdata | input | 2 | Low FIFO control bits: [0] FIFO enable, [1] receive FIFO reset |
| isr | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO pointer reset |

## Verification
The assertions check several things on every cycle: the line-status source always wins, the enhanced bits stay clear while enh_en is low, the two FIFO bits always agree, the Xoff indication holds until Xon, and every reset pulse traces back to a qualifying write one cycle earlier. Only the bench's scenarios can show the full priority ladder as sources are peeled away one by one. The same applies to masking by individual enables, the same-cycle race between Xoff and Xon, and the exact cycle in which FIFO-enable reporting changes after a write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ID_W = 6;

  typedef enum logic [ID_W-1:0] {
    ID_NONE  = 6'b000001,
    ID_LINE  = 6'b000110,
    ID_RXTMO = 6'b001100,
    ID_RXRDY = 6'b000100,
    ID_TXRDY = 6'b000010,
    ID_MODEM = 6'b000000,
    ID_XOFF  = 6'b010000,
    ID_FLOW  = 6'b100000
  } irq_id_e;

  // Level 0 is the most urgent; the order sets the priority.
  function automatic logic [ID_W-1:0] level_code(input int lvl);
    case (lvl)
      0:       level_code = ID_LINE;
      1:       level_code = ID_RXTMO;
      2:       level_code = ID_RXRDY;
      3:       level_code = ID_TXRDY;
      4:       level_code = ID_MODEM;
      5:       level_code = ID_XOFF;
      6:       level_code = ID_FLOW;
      default: level_code = ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int NBASIC = 5,
  localparam int NLVL = NBASIC + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBASIC-1:0] ev_flag,
  input  logic [NBASIC-1:0] ev_en,
  input  logic              flow_chg,
  input  logic              flow_en,
  input  logic              xoff_hit,
  input  logic              xon_hit,
  input  logic              xoff_en,
  input  logic              enh_en,
  output logic [NLVL-1:0]   req
);

  logic xoff_q, xoff_d, xoff_ce;

  // Sticky Xoff indication: set only in enhanced mode, Xon clear wins.
  always_comb begin
    xoff_ce = xon_hit | (xoff_hit & enh_en);
    xoff_d  = xoff_q;
    if (xon_hit)                 xoff_d = 1'b0;
    else if (xoff_hit && enh_en) xoff_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       xoff_q <= 1'b0;
    else if (xoff_ce) xoff_q <= xoff_d;
  end

  genvar g;
  generate
    for (g = 0; g < NBASIC; g++) begin : g_basic
      assign req[g] = ev_flag[g] & ev_en[g];
    end
  endgenerate

  assign req[NBASIC]   = xoff_q & xoff_en & enh_en;
  assign req[NBASIC+1] = flow_chg & flow_en & enh_en;

  // R6: the indication survives until an Xon is seen
  a_r6_xoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_q && !xon_hit) |=> xoff_q);

  // R6: no set outside enhanced mode
  a_r6_xoff_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!xoff_q && !enh_en) |=> !xoff_q);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int NLVL = 7
) (
  input  logic [NLVL-1:0] req,
  output logic [ID_W-1:0] code
);

  // Walk from least to most urgent so the most urgent request is written last.
  always_comb begin
    code = ID_NONE;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (req[i]) code = level_code(i);
    end
  end

endmodule

// File: rtl/fifo_ctl_wr.sv
module fifo_ctl_wr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic       fifo_on,
  output logic       rx_rst
);

  logic fifo_on_d, rx_rst_d;

  always_comb begin
    fifo_on_d = ctl_wr ? ctl_wdata[0] : fifo_on;
    rx_rst_d  = ctl_wr & ctl_wdata[0] & ctl_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      rx_rst  <= 1'b0;
    end else begin
      fifo_on <= fifo_on_d;
      rx_rst  <= rx_rst_d;
    end
  end

  // R9: every pulse comes from a qualifying write one cycle earlier
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> $past(ctl_wr && ctl_wdata == 2'b11));

  // R8: a write without the enable bit leaves the FIFOs off
  a_r8_disable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0]) |=> (!fifo_on && !rx_rst));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int NBASIC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBASIC-1:0] ev_flag,
  input  logic [NBASIC-1:0] ev_en,
  input  logic              flow_chg,
  input  logic              flow_en,
  input  logic              xoff_hit,
  input  logic              xon_hit,
  input  logic              xoff_en,
  input  logic              enh_en,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [7:0]        isr,
  output logic              irq,
  output logic              rx_fifo_rst
);

  localparam int NLVL = NBASIC + 2;

  logic [NLVL-1:0] req;
  logic [ID_W-1:0] code;
  logic            fifo_on;

  irq_src_gate #(.NBASIC(NBASIC)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_flag  (ev_flag),
    .ev_en    (ev_en),
    .flow_chg (flow_chg),
    .flow_en  (flow_en),
    .xoff_hit (xoff_hit),
    .xon_hit  (xon_hit),
    .xoff_en  (xoff_en),
    .enh_en   (enh_en),
    .req      (req)
  );

  irq_prio_enc #(.NLVL(NLVL)) u_enc (
    .req  (req),
    .code (code)
  );

  fifo_ctl_wr u_fcr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .fifo_on   (fifo_on),
    .rx_rst    (rx_fifo_rst)
  );

  assign isr = {{2{fifo_on}}, code};
  assign irq = ~code[0];

  // R2: line status beats every other source
  a_r2_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flag[0] && ev_en[0]) |-> (isr[5:0] == ID_LINE));

  // R5: enhanced sources are silent outside enhanced mode
  a_r5_enh_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> (isr[5:4] == 2'b00));

  // R7: both FIFO status bits move together
  a_r7_fifo_pair: assert property (@(posedge clk) disable iff (!rst_n)
    isr[7] == isr[6]);

  // R1: nothing enabled means the idle code and no request
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_flag & ev_en) == '0 && !enh_en) |-> (isr[5:0] == ID_NONE && !irq));

endmodule

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ev_flag, ev_en;
  logic       flow_chg, flow_en, xoff_hit, xon_hit, xoff_en, enh_en;
  logic       ctl_wr;
  logic [1:0] ctl_wdata;
  logic [7:0] isr;
  logic       irq, rx_fifo_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ev_flag(ev_flag), .ev_en(ev_en),
    .flow_chg(flow_chg), .flow_en(flow_en), .xoff_hit(xoff_hit),
    .xon_hit(xon_hit), .xoff_en(xoff_en), .enh_en(enh_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .isr(isr), .irq(irq),
    .rx_fifo_rst(rx_fifo_rst)
  );

  // [19:15] flag, [14:10] en, [9] flow_chg, [8] flow_en, [7] xoff_en, [6] enh_en, [5:0] expected code
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {5'b00000, 5'b11111, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000001},  // R1 idle
    {5'b11111, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b000110},  // R2 line
    {5'b11110, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b001100},  // R3 timeout
    {5'b11100, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b000100},  // R3 rx ready
    {5'b11000, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b000010},  // R3 tx ready
    {5'b10000, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b000000},  // R3 modem
    {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b1, 6'b100000},  // R2 flow
    {5'b00000, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b0, 6'b000001},  // R5 enh off
    {5'b00000, 5'b11111, 1'b1, 1'b0, 1'b1, 1'b1, 6'b000001},  // R5 flow_en off
    {5'b00101, 5'b11110, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000100},  // R4 line masked
    {5'b11111, 5'b00000, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000001},  // R4 all masked
    {5'b11000, 5'b10111, 1'b0, 1'b1, 1'b1, 1'b1, 6'b000000}   // R4 tx masked
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev_flag = '0; ev_en = '0; flow_chg = 0; flow_en = 0;
    xoff_hit = 0; xon_hit = 0; xoff_en = 0; enh_en = 0; ctl_wr = 0; ctl_wdata = '0;
    #12;
    // R7 R10 R1: reset state
    chk("R7 reset isr", isr, 8'b0000_0001);
    chk("R10 reset irq", {7'd0, irq}, 8'd0);
    chk("R9 reset pulse", {7'd0, rx_fifo_rst}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ev_flag = VEC[v][19:15]; ev_en = VEC[v][14:10];
      flow_chg = VEC[v][9]; flow_en = VEC[v][8];
      xoff_en = VEC[v][7]; enh_en = VEC[v][6];
      #1;
      chk($sformatf("R2 vector %0d isr", v), isr, {2'b00, VEC[v][5:0]});
      chk($sformatf("R10 vector %0d irq", v), {7'd0, irq}, {7'd0, ~VEC[v][0]});
    end

    // R6: sticky Xoff
    @(negedge clk);
    ev_flag = '0; ev_en = 5'b11111; flow_chg = 0; flow_en = 1; xoff_en = 1; enh_en = 1;
    xoff_hit = 1;
    tick; xoff_hit = 0;
    chk("R6 xoff set", isr, 8'b0001_0000);
    tick; tick;
    chk("R6 xoff held", isr, 8'b0001_0000);
    flow_chg = 1; #0.5;
    chk("R2 xoff over flow", isr, 8'b0001_0000);
    ev_flag = 5'b10000; #0.5;
    chk("R2 modem over xoff", isr, 8'b0000_0000);
    ev_flag = '0; flow_chg = 0; enh_en = 0; #0.5;
    chk("R5 xoff hidden", isr, 8'b0000_0001);
    enh_en = 1; #0.5;
    chk("R6 xoff still held", isr, 8'b0001_0000);
    @(negedge clk); xon_hit = 1;
    tick; xon_hit = 0;
    chk("R6 xon clears", isr, 8'b0000_0001);
    enh_en = 0; xoff_hit = 1;
    tick; xoff_hit = 0; enh_en = 1; #0.5;
    chk("R6 set ignored without enh", isr, 8'b0000_0001);
    @(negedge clk); xoff_hit = 1; xon_hit = 1;
    tick; xoff_hit = 0; xon_hit = 0;
    chk("R6 xon wins race", isr, 8'b0000_0001);

    // R8 R9: FIFO control writes
    @(negedge clk); ctl_wr = 1; ctl_wdata = 2'b01;
    tick; ctl_wr = 0;
    chk("R8 enable write", isr, 8'b1100_0001);
    chk("R9 no pulse on plain enable", {7'd0, rx_fifo_rst}, 8'd0);
    @(negedge clk); ctl_wr = 1; ctl_wdata = 2'b11;
    tick; ctl_wr = 0;
    chk("R9 pulse high", {7'd0, rx_fifo_rst}, 8'd1);
    tick;
    chk("R9 pulse one cycle", {7'd0, rx_fifo_rst}, 8'd0);
    chk("R7 fifo still on", isr, 8'b1100_0001);
    @(negedge clk); ctl_wr = 1; ctl_wdata = 2'b10;
    tick; ctl_wr = 0;
    chk("R9 no pulse without bit0", {7'd0, rx_fifo_rst}, 8'd0);
    chk("R8 disable write", isr, 8'b0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule